// File: doc/BRIEF.md
# Two-Level Victim Selector for an Eight-Way Cache

This block holds the replacement history for every set of an eight-way set-associative cache and names the way to evict when a lookup misses. The ways are handled in four pairs: ways 2k and 2k+1 form pair k. The first level keeps, for each set, a six-bit triangular matrix. Each bit records which of two pairs was used more recently. The second level keeps one bit per pair that says which of its two ways was touched last.

The cache controller presents a set index on every cycle. A hit is reported with a hit strobe and the 3-bit way that hit. A miss is reported with a miss request. The victim way is derived combinationally from the stored state of the addressed set and is flagged valid during the same cycle. The refill of that victim is treated as an access at the next clock edge, so no separate refill port is needed. Tag comparison and data movement belong to the surrounding cache.

Top module: `pair_lru8_top`

## Requirements
- R1: Ways 2k and 2k+1 belong to pair k (k = 0..3). The victim way is twice the selected pair number plus the in-pair choice.
- R2: The selected pair is the pair of the addressed set that was accessed least recently, counting hits and refills.
- R3: Inside the selected pair, a stored pair bit of 0 selects the even way (2k) and a bit of 1 selects the odd way (2k+1).
- R4: A hit on way w in set s makes pair w/2 the most recently used pair of set s from the next clock edge on.
- R5: An access to an even way writes that pair's bit to 1. An access to an odd way writes it to 0. The old value is not read.
- R6: When missReq is 1 and hitValid is 0, victimValid is 1 and victimWay holds the victim in the same cycle. At the following clock edge, that victim counts as accessed (R4, R5).
- R7: When hitValid and missReq are both 1, the hit takes priority. victimValid is 0, and only the hit way updates the state.
- R8: After reset, every set has all matrix and pair bits at 0. Eight back-to-back misses on a fresh set therefore return ways 0, 2, 4, 6, 1, 3, 5, 7.
- R9: An access to one set leaves the replacement state of every other set unchanged.
- R10: victimValid is 0 in every cycle without a miss request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state updates on the rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| setIdx | input | SET_W | Set addressed this cycle |
| hitValid | input | 1 | A hit occurred in the addressed set |
| hitWay | input | 3 | Way that hit |
| missReq | input | 1 | A miss occurred; a victim is requested |
| victimWay | output | 3 | Way chosen for replacement |
| victimValid | output | 1 | victimWay is meaningful this cycle |

## Verification
The victim and its valid flag are combinational, so each is due in the cycle in which the miss is presented. The state change caused by a hit or refill becomes visible only from the next cycle on. The bench drives inputs on the falling edge and pushes one expected entry per cycle into a scoreboard queue. A monitor pops and compares that entry a short delay after the same falling edge. Each expected value comes from a recency list and last-touched bit per set, which the driver advances only after it has computed the expectation for that cycle.

// File: rtl/pair_lru8_pkg.sv
package pair_lru8_pkg;
  localparam int WAYS   = 8;
  localparam int WAY_W  = $clog2(WAYS);
  localparam int PAIRS  = WAYS / 2;
  localparam int PAIR_W = $clog2(PAIRS);
  localparam int MAT_BITS = PAIRS * (PAIRS - 1) / 2;
  localparam int MAT_IDX_W = (MAT_BITS > 1) ? $clog2(MAT_BITS) : 1;

  typedef struct packed {
    logic             touch;
    logic [WAY_W-1:0] way;
  } touch_strobe_t;
endpackage

// File: rtl/pair_lru8_ctrl.sv
module pair_lru8_ctrl
  import pair_lru8_pkg::*;
(
  input  logic             hitValid,
  input  logic [WAY_W-1:0] hitWay,
  input  logic             missReq,
  input  logic [WAY_W-1:0] chosenWay,
  output touch_strobe_t    strobe,
  output logic             victimValid
);
  // A hit has priority over a simultaneous miss request.
  logic takeMiss;

  always_comb begin
    takeMiss     = missReq & ~hitValid;
    victimValid  = takeMiss;
    strobe.touch = hitValid | takeMiss;
    strobe.way   = hitValid ? hitWay : chosenWay;
  end
endmodule

// File: rtl/pair_lru8_state.sv
module pair_lru8_state
  import pair_lru8_pkg::*;
#(
  parameter int NUM_SETS = 16,
  localparam int SET_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SET_W-1:0] setIdx,
  input  touch_strobe_t    strobe,
  output logic [WAY_W-1:0] chosenWay
);
  logic [MAT_BITS-1:0] orderMat [NUM_SETS];
  logic [PAIRS-1:0]    pairBits [NUM_SETS];

  logic [MAT_BITS-1:0] curMat, nextMat;
  logic [PAIRS-1:0]    curBits, nextBits;
  logic [PAIRS-1:0]    lruCand;
  logic [PAIR_W-1:0]   lruPair;
  logic [PAIR_W-1:0]   touchPair;

  function automatic logic [MAT_IDX_W-1:0] matIdx(input int i, input int j);
    int v;
    v = i * PAIRS - (i * (i + 1)) / 2 + (j - i - 1);
    return MAT_IDX_W'(v);
  endfunction

  assign curMat    = orderMat[setIdx];
  assign curBits   = pairBits[setIdx];
  assign touchPair = strobe.way[WAY_W-1:1];

  // Bit (i,j), i<j, set means pair i is newer than pair j.
  // The oldest pair is newer than nobody.
  always_comb begin
    for (int p = 0; p < PAIRS; p++) begin
      lruCand[p] = 1'b1;
      for (int q = 0; q < PAIRS; q++) begin
        if (q > p && curMat[matIdx(p, q)])  lruCand[p] = 1'b0;
        if (q < p && !curMat[matIdx(q, p)]) lruCand[p] = 1'b0;
      end
    end
    lruPair = '0;
    for (int p = PAIRS - 1; p >= 0; p--) begin
      if (lruCand[p]) lruPair = PAIR_W'(p);
    end
    chosenWay = {lruPair, curBits[lruPair]};
  end

  always_comb begin
    nextMat  = curMat;
    nextBits = curBits;
    for (int p = 0; p < PAIRS; p++) begin
      for (int q = 0; q < PAIRS; q++) begin
        if (q > p && int'(touchPair) == p) nextMat[matIdx(p, q)] = 1'b1;
        if (q > p && int'(touchPair) == q) nextMat[matIdx(p, q)] = 1'b0;
      end
    end
    nextBits[touchPair] = ~strobe.way[0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        orderMat[s] <= '0;
        pairBits[s] <= '0;
      end
    end else if (strobe.touch) begin
      orderMat[setIdx] <= nextMat;
      pairBits[setIdx] <= nextBits;
    end
  end

  // R2: the matrix always names exactly one oldest pair
  a_r2_single_lru: assert property (@(posedge clk) disable iff (!rstN)
    $onehot(lruCand));

  // R4: the pair just touched is never the next victim of that set
  a_r4_mru_not_victim: assert property (@(posedge clk) disable iff (!rstN)
    strobe.touch |=> (setIdx != $past(setIdx)) || (lruPair != $past(touchPair)));

  // R5: even access writes 1, odd access writes 0
  a_r5_even_sets: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.touch && !strobe.way[0]) |=> pairBits[$past(setIdx)][$past(touchPair)]);

  a_r5_odd_clears: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.touch && strobe.way[0]) |=> !pairBits[$past(setIdx)][$past(touchPair)]);
endmodule

// File: rtl/pair_lru8_top.sv
module pair_lru8_top
  import pair_lru8_pkg::*;
#(
  parameter int NUM_SETS = 16,
  localparam int SET_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SET_W-1:0] setIdx,
  input  logic             hitValid,
  input  logic [2:0]       hitWay,
  input  logic             missReq,
  output logic [2:0]       victimWay,
  output logic             victimValid
);
  touch_strobe_t    strobe;
  logic [WAY_W-1:0] chosenWay;

  pair_lru8_ctrl u_ctrl (
    .hitValid    (hitValid),
    .hitWay      (hitWay),
    .missReq     (missReq),
    .chosenWay   (chosenWay),
    .strobe      (strobe),
    .victimValid (victimValid)
  );

  pair_lru8_state #(.NUM_SETS(NUM_SETS)) u_state (
    .clk       (clk),
    .rstN      (rstN),
    .setIdx    (setIdx),
    .strobe    (strobe),
    .chosenWay (chosenWay)
  );

  assign victimWay = chosenWay;

  // R10: no victim flagged without a miss request
  a_r10_valid_needs_miss: assert property (@(posedge clk) disable iff (!rstN)
    victimValid |-> missReq);
endmodule

// File: tb/pair_lru8_top_bench.sv
module pair_lru8_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_SETS = 16;
  localparam int SET_W = $clog2(NUM_SETS);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [SET_W-1:0] setIdx = '0;
  logic hitValid = 1'b0;
  logic [2:0] hitWay = '0;
  logic missReq = 1'b0;
  logic [2:0] victimWay;
  logic victimValid;

  int checks = 0;
  int errors = 0;
  int expQ[$];
  string tagQ[$];

  // Reference: recency list of pairs (index 0 = oldest) and last-touched bit
  int ord [NUM_SETS][4];
  bit lastEven [NUM_SETS][4];

  pair_lru8_top #(.NUM_SETS(NUM_SETS)) u_pair_lru8_top (
    .clk(clk), .rstN(rstN), .setIdx(setIdx), .hitValid(hitValid),
    .hitWay(hitWay), .missReq(missReq), .victimWay(victimWay),
    .victimValid(victimValid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic modelReset();
    for (int s = 0; s < NUM_SETS; s++)
      for (int p = 0; p < 4; p++) begin
        ord[s][p] = p;        // R8: pair 0 oldest after reset
        lastEven[s][p] = 1'b0;
      end
  endtask

  function automatic int modelVictim(int s);
    int p;
    p = ord[s][0];
    return 2 * p + (lastEven[s][p] ? 1 : 0);
  endfunction

  task automatic modelTouch(int s, int w);
    int p, k;
    p = w / 2;
    k = 0;
    while (ord[s][k] != p) k++;
    for (int i = k; i < 3; i++) ord[s][i] = ord[s][i+1];
    ord[s][3] = p;
    lastEven[s][p] = (w % 2 == 0);
  endtask

  // driver: one call per cycle, one scoreboard entry per cycle
  task automatic op(int s, bit hv, int hw, bit mv, string tag);
    int e;
    @(negedge clk);
    setIdx = SET_W'(s);
    hitValid = hv;
    hitWay = 3'(hw);
    missReq = mv;
    e = -1;
    if (hv) modelTouch(s, hw);
    else if (mv) begin
      e = modelVictim(s);
      modelTouch(s, e);
    end
    expQ.push_back(e);
    tagQ.push_back(tag);
  endtask

  // monitor
  always @(negedge clk) begin
    int e;
    string t;
    #2;
    if (expQ.size() > 0) begin
      e = expQ.pop_front();
      t = tagQ.pop_front();
      checks++;
      if (e < 0) begin
        if (victimValid !== 1'b0) begin
          errors++;
          $display("FAIL %s victimValid act=%0b exp=0", t, victimValid);
        end
      end else if (victimValid !== 1'b1 || int'(victimWay) != e) begin
        errors++;
        $display("FAIL %s valid=%0b way act=%0d exp=%0d", t, victimValid, victimWay, e);
      end
    end
  end

  initial begin
    int cyc;
    cyc = 0;
    while (cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R10: idle cycles show no victim
    for (int i = 0; i < 3; i++) op(0, 0, 0, 0, "R10");
    // R8 / R1 / R3 / R6: fresh set sequence 0,2,4,6,1,3,5,7
    for (int i = 0; i < 8; i++) op(3, 0, 0, 1, "R8");
    // R2 / R4 / R5: hits reorder pairs and flip in-pair bits
    op(5, 1, 6, 0, "R4");
    op(5, 1, 1, 0, "R5");
    op(5, 1, 0, 0, "R5");
    op(5, 0, 0, 1, "R2");
    op(5, 0, 0, 1, "R3");
    op(5, 1, 5, 0, "R4");
    op(5, 0, 0, 1, "R2");
    // R7: hit and miss together, hit wins
    op(7, 1, 3, 1, "R7");
    op(7, 0, 0, 1, "R7");
    op(7, 1, 2, 1, "R7");
    op(7, 0, 0, 1, "R7");
    // R9: hammer set 1 then check an untouched set
    for (int i = 0; i < 6; i++) op(1, 1, i, 0, "R9");
    op(2, 0, 0, 1, "R9");
    op(1, 0, 0, 1, "R9");
    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      int s, k;
      s = int'($urandom_range(NUM_SETS - 1));
      k = int'($urandom_range(3));
      case (k)
        0: op(s, 1, int'($urandom_range(7)), 0, "R4");
        1: op(s, 0, 0, 1, "R2");
        2: op(s, 1, int'($urandom_range(7)), 1, "R7");
        default: op(s, 0, 0, 0, "R10");
      endcase
    end
    op(0, 0, 0, 0, "R10");
    repeat (2) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule